// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets any processor core raise software interrupts on one or more other cores with a single register write. Each core has its own register port into the unit. A write to the trigger register carries a doorbell index in its low byte and a map of target cores above it. Every targeted core gets the matching bit set in its private pending-doorbell register.

Each core also owns an enable register. The enable register selects which pending doorbells drive that core's summary interrupt line. The interrupt router receives the summary line as source number 0. Software acknowledges doorbells by writing its pending register: bits written as zero are cleared, so a write of zero drops them all. Core count and doorbell count are parameters, checked at elaboration.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every core reads 0 from its pending register (offset 0x8) and its enable register (offset 0xC), and every summary output is low.
- R2: A write to offset 0x4 with doorbell index k (bits [7:0]) and bit 8+n set in the data sets pending bit k of core n. The new bit is readable on the cycle after the write. Cores whose target bit is clear keep their pending value.
- R3: A trigger write whose index is NUM_BELLS or greater changes no pending register. Target bits above the last core are ignored.
- R4: A write to a core's own pending register (offset 0x8) keeps only the bits written as 1. A write of 0 clears every pending doorbell of that core.
- R5: If a doorbell is set for a core in the same cycle that the core clears its pending register, the new doorbell bit is kept.
- R6: A write to offset 0xC loads the core's enable register from data bits [NUM_BELLS-1:0]. The value reads back at 0xC.
- R7: A core's summary output is high exactly when some pending bit of that core is also enabled. It follows the registered pending and enable values.
- R8: Trigger writes from several cores in one cycle all take effect, and their doorbell bits are ORed per target core.
- R9: Reads of offset 0x4 and of unmapped offsets return 0. Reads of the pending and enable registers return 0 above bit NUM_BELLS-1.
- R10: A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_we | input | NUM_CPUS | Per-core write strobe |
| core_addr | input | NUM_CPUS*ADDR_W | Per-core register offset, core c in slice c |
| core_wdata | input | NUM_CPUS*32 | Per-core write data |
| core_rdata | output | NUM_CPUS*32 | Per-core read data, combinational from the offset |
| db_irq | output | NUM_CPUS | Per-core doorbell summary interrupt, router source 0 |

## Verification
On every cycle the assertions check four things: a newly set doorbell bit is present on the next cycle, even when a clear hits in the same cycle; no pending bit rises without a set request; a clear-all write leaves nothing pending; and an enable write loads its value. They also check that trigger decoding ignores out-of-range indices. Only the bench scenarios can show the full fan-out pattern, because that depends on the register read-back path. The same holds for merging triggers from several cores in one cycle, the summary under every enable value, and the zero read-back of unmapped offsets.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned OFFS_TRIG   = 4;
   localparam int unsigned OFFS_PEND   = 8;
   localparam int unsigned OFFS_ENA    = 12;
   localparam int unsigned IDX_W       = 8;   // doorbell index field, low bits of trigger data
   localparam int unsigned TGT_LSB     = 8;   // target core n at bit TGT_LSB+n
   localparam int unsigned MAX_BELLS   = 8;
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned NUM_BELLS = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  we,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [REG_W-1:0]                      wdata,
   output logic [NUM_CPUS-1:0][NUM_BELLS-1:0]    set_o
);
   logic                 hit;
   logic [IDX_W-1:0]     idx;
   logic [NUM_BELLS-1:0] bell_oh;

   assign hit = we && (addr == ADDR_W'(OFFS_TRIG));
   assign idx = wdata[IDX_W-1:0];

   for (genvar b = 0; b < NUM_BELLS; b++) begin : g_oh
      assign bell_oh[b] = (idx == IDX_W'(b));
   end

   for (genvar n = 0; n < NUM_CPUS; n++) begin : g_tgt
      assign set_o[n] = (hit && wdata[TGT_LSB+n]) ? bell_oh : '0;
   end

   AST_IGNORE_HIGH_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx >= IDX_W'(NUM_BELLS)) |-> (set_o == '0)); // R3
   AST_NO_SET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |-> (set_o == '0)); // R10
endmodule

// File: rtl/db_cpu_slot.sv
module db_cpu_slot
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_BELLS = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic [NUM_BELLS-1:0] set_i,
   output logic [REG_W-1:0]     rdata,
   output logic                 irq
);
   localparam int unsigned PAD_W = REG_W - NUM_BELLS;

   logic [NUM_BELLS-1:0] pend_q, ena_q, pend_nxt;
   logic                 pend_wr, ena_wr;

   assign pend_wr = we && (addr == ADDR_W'(OFFS_PEND));
   assign ena_wr  = we && (addr == ADDR_W'(OFFS_ENA));

   // set requests win over a same-cycle clear
   assign pend_nxt = (pend_wr ? (pend_q & wdata[NUM_BELLS-1:0]) : pend_q) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         ena_q  <= '0;
      end else begin
         pend_q <= pend_nxt;
         if (ena_wr) ena_q <= wdata[NUM_BELLS-1:0];
      end
   end

   always_comb begin
      if (addr == ADDR_W'(OFFS_PEND))     rdata = {{PAD_W{1'b0}}, pend_q};
      else if (addr == ADDR_W'(OFFS_ENA)) rdata = {{PAD_W{1'b0}}, ena_q};
      else                                rdata = '0;
   end

   assign irq = |(pend_q & ena_q);

   for (genvar b = 0; b < NUM_BELLS; b++) begin : g_chk
      AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> pend_q[b]); // R5
   end
   AST_NO_STRAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0)); // R3
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && wdata[NUM_BELLS-1:0] == '0 && set_i == '0) |=> (pend_q == '0)); // R4
   AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ena_wr |=> (ena_q == $past(wdata[NUM_BELLS-1:0]))); // R6
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
   import doorbell_pkg::*;
#(
   parameter int unsigned NUM_CPUS  = 4,
   parameter int unsigned NUM_BELLS = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CPUS-1:0]          core_we,
   input  logic [NUM_CPUS*ADDR_W-1:0]   core_addr,
   input  logic [NUM_CPUS*REG_W-1:0]    core_wdata,
   output logic [NUM_CPUS*REG_W-1:0]    core_rdata,
   output logic [NUM_CPUS-1:0]          db_irq
);
   if (NUM_CPUS < 1 || NUM_CPUS > REG_W - TGT_LSB) begin : g_bad_cpus
      $error("doorbell_unit: NUM_CPUS out of range");
   end
   if (NUM_BELLS < 1 || NUM_BELLS > MAX_BELLS) begin : g_bad_bells
      $error("doorbell_unit: NUM_BELLS out of range");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("doorbell_unit: ADDR_W too narrow for register offsets");
   end

   // set requests indexed [writer][target][bell]
   logic [NUM_CPUS-1:0][NUM_CPUS-1:0][NUM_BELLS-1:0] set_by_wr;
   logic [NUM_CPUS-1:0][NUM_BELLS-1:0]               set_to;

   for (genvar w = 0; w < NUM_CPUS; w++) begin : g_wr
      db_trig_decode #(
         .NUM_CPUS (NUM_CPUS),
         .NUM_BELLS(NUM_BELLS),
         .ADDR_W   (ADDR_W)
      ) u_dec (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (core_we[w]),
         .addr (core_addr[w*ADDR_W +: ADDR_W]),
         .wdata(core_wdata[w*REG_W +: REG_W]),
         .set_o(set_by_wr[w])
      );
   end

   always_comb begin
      for (int n = 0; n < NUM_CPUS; n++) begin
         set_to[n] = '0;
         for (int w = 0; w < NUM_CPUS; w++) begin
            set_to[n] = set_to[n] | set_by_wr[w][n];
         end
      end
   end

   for (genvar n = 0; n < NUM_CPUS; n++) begin : g_slot
      db_cpu_slot #(
         .NUM_BELLS(NUM_BELLS),
         .ADDR_W   (ADDR_W)
      ) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (core_we[n]),
         .addr (core_addr[n*ADDR_W +: ADDR_W]),
         .wdata(core_wdata[n*REG_W +: REG_W]),
         .set_i(set_to[n]),
         .rdata(core_rdata[n*REG_W +: REG_W]),
         .irq  (db_irq[n])
      );
   end
endmodule

// File: tb/doorbell_unit_test.sv
module doorbell_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NB = 8;
   localparam int AW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NC-1:0]     we = '0;
   logic [NC*AW-1:0]  addr = '0;
   logic [NC*32-1:0]  wdata = '0;
   logic [NC*32-1:0]  rdata;
   logic [NC-1:0]     irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   doorbell_unit #(.NUM_CPUS(NC), .NUM_BELLS(NB), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .core_we(we), .core_addr(addr),
      .core_wdata(wdata), .core_rdata(rdata), .db_irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input int c, input logic [AW-1:0] a, input logic [31:0] d);
      we[c] = 1'b1;
      addr[c*AW +: AW] = a;
      wdata[c*32 +: 32] = d;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      we = '0;
   endtask

   task automatic rd(input int c, input logic [AW-1:0] a, output logic [31:0] v);
      addr[c*AW +: AW] = a;
      #1;
      v = rdata[c*32 +: 32];
   endtask

   task automatic clear_all();
      for (int c = 0; c < NC; c++) put(c, 4'h8, 32'h0);
      tick();
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] e;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int c = 0; c < NC; c++) begin
         rd(c, 4'h8, v); check("R1 pend reset", v, 0);
         rd(c, 4'hC, v); check("R1 ena reset", v, 0);
         check("R1 irq reset", {31'b0, irq[c]}, 0);
      end

      // R6 enable all bells on every core
      for (int c = 0; c < NC; c++) put(c, 4'hC, 32'hFFFF_FFFF);
      tick();
      for (int c = 0; c < NC; c++) begin
         rd(c, 4'hC, v); check("R6 ena load / R9 upper zero", v, 32'hFF);
      end

      // R2 R3 R4 R7 sweep of index and target map
      for (int num = 0; num < 16; num++) begin
         for (int map = 0; map < 16; map++) begin
            int w;
            w = (num + map) % NC;
            clear_all();
            put(w, 4'h4, (32'(map) << 8) | 32'(num) | 32'hF000);
            tick();
            for (int c = 0; c < NC; c++) begin
               e = (num < NB && map[c]) ? (32'h1 << num) : 32'h0;
               rd(c, 4'h8, v);
               check(num < NB ? "R2 fanout" : "R3 high index ignored", v, e);
               check("R7 irq under full enable", {31'b0, irq[c]}, {31'b0, e != 0});
            end
         end
      end

      // build pattern A5 on core 2
      clear_all();
      for (int b = 0; b < NB; b++) begin
         if (b == 0 || b == 2 || b == 5 || b == 7) begin
            put(0, 4'h4, 32'h400 | 32'(b));
            tick();
         end
      end
      // R7 enable sweep
      for (int m = 0; m < 256; m++) begin
         put(2, 4'hC, 32'(m));
         tick();
         rd(2, 4'hC, v); check("R6 ena readback", v, 32'(m));
         check("R7 irq vs enable", {31'b0, irq[2]}, {31'b0, (m & 8'hA5) != 0});
      end

      // R4 partial clear keeps bits written as 1
      put(2, 4'h8, 32'h0000_0021);
      tick();
      rd(2, 4'h8, v); check("R4 partial clear", v, 32'h21);
      put(2, 4'h8, 32'h0);
      tick();
      rd(2, 4'h8, v); check("R4 clear all", v, 32'h0);

      // R5 set wins over same-cycle clear
      put(0, 4'h4, 32'h200 | 32'd0);
      tick();
      put(0, 4'h4, 32'h200 | 32'd3);
      put(1, 4'h8, 32'h0);
      tick();
      rd(1, 4'h8, v); check("R5 set beats clear", v, 32'h08);

      // R8 simultaneous triggers from two cores
      clear_all();
      put(0, 4'h4, 32'h800 | 32'd1);
      put(2, 4'h4, 32'h900 | 32'd6);
      tick();
      rd(3, 4'h8, v); check("R8 merged core3", v, 32'h42);
      rd(0, 4'h8, v); check("R8 merged core0", v, 32'h40);
      rd(1, 4'h8, v); check("R8 untouched core1", v, 32'h0);

      // R9 reads of trigger and unmapped offsets
      rd(3, 4'h4, v); check("R9 trigger reads zero", v, 0);
      rd(3, 4'h0, v); check("R9 unmapped reads zero", v, 0);
      rd(3, 4'hF, v); check("R9 unmapped reads zero", v, 0);

      // R10 unmapped writes do nothing
      put(3, 4'h0, 32'h0);
      tick();
      put(3, 4'h9, 32'h0);
      tick();
      rd(3, 4'h8, v); check("R10 pend kept", v, 32'h42);
      rd(3, 4'hC, v); check("R10 ena kept", v, 32'hFF);
      check("R10 irq kept", {31'b0, irq[3]}, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule